// File: doc/BRIEF.md
# Multi-Bank Write Command Scheduler

This block turns write requests into command traffic for a four-bank DRAM whose accesses each take two commands. The first command opens a bank and carries the upper address. The second follows in the very next cycle and carries the lower address. A request arrives on a valid/ready port. It carries a bank number, both address halves, a burst-length flag and up to four data words.

The scheduler applies two spacing rules when it accepts a request. Two bank-open commands are at least two cycles apart. Two bank-open commands to the same bank are at least five cycles apart. The second rule also covers the four cycles in which a bank stays active. Requests are taken strictly in arrival order. A request that its bank's timing blocks holds the port, and nothing behind it can pass.

The block presents write data as double-rate word pairs, with one pair per clock. The first pair appears a write latency after the lower-address command. That latency is one less than the CAS latency chosen by a mode input. A strobe lane shows the level for each half of the cycle, and a low preamble cycle comes before each burst that does not directly continue a previous one.

Top module: `nw_write_sched`

## Requirements
- R1: While reset is held, `cmd` is deselect (2'b00) and `dq_oe` and `dqs_oe` are low. The first cycle after reset shows `req_ready` high.
- R2: On the cycle after a handshake, `cmd` is bank-open (2'b01), with the request's bank on `bank_out` and its upper address on `addr_out`. On the cycle after that, `cmd` is lower-address latch (2'b10), with the lower address on `addr_out`.
- R3: Two bank-open commands are at least 2 cycles apart. Back-to-back requests to different banks are issued exactly 2 cycles apart.
- R4: Two bank-open commands to the same bank are at least 5 cycles apart. A second request to the same bank is issued exactly 5 cycles after the first.
- R5: Every cycle that carries neither a bank-open nor a latch command shows deselect (2'b00).
- R6: The first data pair is driven (`dq_oe` high) WL cycles after the latch command, and `dq_oe` is low in the cycle before it. WL = 2 when `cas_lat4` = 0 and WL = 3 when `cas_lat4` = 1.
- R7: Request word k sits at `req_data[k*DW +: DW]`. On `dq_pair`, the low half is the rising-edge word and the high half is the falling-edge word. When `req_long` = 0, one cycle carries words 0 and 1. When `req_long` = 1, a second cycle carries words 2 and 3. `dq_oe` then drops unless a new burst follows.
- R8: On every data cycle `dqs_oe` is high and `dqs_half` = 2'b01 (high in the first half, low in the second), so the strobe toggles once per word. In the cycle before a burst's first data cycle, `dqs_oe` is high with `dqs_half` = 2'b00 and `dq_oe` low. The exception is a burst that directly follows another, where that cycle carries the previous burst's data instead.
- R9: While the request at the port is blocked by its bank's cycle time, `req_ready` stays low and no bank-open command is issued for any bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat4 | input | 1 | 0: CAS latency 3 (WL 2); 1: CAS latency 4 (WL 3) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_bank | input | 2 | Target bank |
| req_upper | input | AW | Upper address, sent with the bank-open command |
| req_lower | input | AW | Lower address, sent with the latch command |
| req_long | input | 1 | 0: two-word burst; 1: four-word burst |
| req_data | input | 4*DW | Write words, word k at bits k*DW |
| cmd | output | 2 | 00 deselect, 01 bank-open write, 10 lower-address latch |
| bank_out | output | 2 | Bank address (zero when not meaningful) |
| addr_out | output | AW | Address bus |
| dq_pair | output | 2*DW | Rising word (low half) and falling word (high half) |
| dq_oe | output | 1 | Data bus driven |
| dqs_half | output | 2 | Strobe level per half cycle, bit 0 first half |
| dqs_oe | output | 1 | Strobe driven |

## Verification
The assertions assume that `cas_lat4` changes only while no access is in flight, and that the request fields stay stable while `req_valid` waits for `req_ready`. The bench changes the latency mode only after long idle gaps. It sets request fields on the falling edge and holds them until the handshake edge. It drops `req_valid` right after that edge, so every accepted request is presented exactly once.

// File: rtl/nw_write_sched.sv
`timescale 1ns/1ps
module nw_write_sched #(
  parameter int DW     = 16,
  parameter int AW     = 15,
  parameter int T_RC   = 5,
  parameter int T_RBD  = 2,
  parameter int MAX_WL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cas_lat4,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_bank,
  input  logic [AW-1:0]   req_upper,
  input  logic [AW-1:0]   req_lower,
  input  logic            req_long,
  input  logic [4*DW-1:0] req_data,
  output logic [1:0]      cmd,
  output logic [1:0]      bank_out,
  output logic [AW-1:0]   addr_out,
  output logic [2*DW-1:0] dq_pair,
  output logic            dq_oe,
  output logic [1:0]      dqs_half,
  output logic            dqs_oe
);
  localparam logic [1:0] CMD_NOP  = 2'b00;
  localparam logic [1:0] CMD_OPEN = 2'b01;
  localparam logic [1:0] CMD_LAT  = 2'b10;
  localparam int CW    = $clog2(T_RC + 1);
  localparam int DEPTH = MAX_WL + 3;

  logic [CW-1:0]   bank_cnt [4];
  logic [CW-1:0]   gap_cnt;
  logic            lat_pend;
  logic [AW-1:0]   lat_addr;
  logic            dl_v [DEPTH];
  logic            dl_l [DEPTH];
  logic [4*DW-1:0] dl_d [DEPTH];
  logic [2:0]      wl;
  logic            take;

  assign req_ready = (gap_cnt == '0) && (bank_cnt[req_bank] == '0) && !lat_pend;
  assign take      = req_valid && req_ready;
  assign wl        = cas_lat4 ? 3'd3 : 3'd2;

  for (genvar b = 0; b < 4; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)                          bank_cnt[b] <= '0;
      else if (take && req_bank == 2'(b))  bank_cnt[b] <= CW'(T_RC - 1);
      else if (bank_cnt[b] != '0)          bank_cnt[b] <= bank_cnt[b] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              gap_cnt <= '0;
    else if (take)           gap_cnt <= CW'(T_RBD - 1);
    else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd      <= CMD_NOP;
      bank_out <= '0;
      addr_out <= '0;
      lat_pend <= 1'b0;
      lat_addr <= '0;
    end else if (take) begin
      cmd      <= CMD_OPEN;
      bank_out <= req_bank;
      addr_out <= req_upper;
      lat_pend <= 1'b1;
      lat_addr <= req_lower;
    end else if (lat_pend) begin
      cmd      <= CMD_LAT;
      bank_out <= '0;
      addr_out <= lat_addr;
      lat_pend <= 1'b0;
    end else begin
      cmd      <= CMD_NOP;
      bank_out <= '0;
      addr_out <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        dl_v[i] <= 1'b0;
        dl_l[i] <= 1'b0;
        dl_d[i] <= '0;
      end
    end else begin
      dl_v[0] <= take;
      dl_l[0] <= req_long;
      dl_d[0] <= req_data;
      for (int i = 1; i < DEPTH; i++) begin
        dl_v[i] <= dl_v[i-1];
        dl_l[i] <= dl_l[i-1];
        dl_d[i] <= dl_d[i-1];
      end
    end
  end

  always_comb begin
    dq_pair  = '0;
    dq_oe    = 1'b0;
    dqs_half = 2'b00;
    dqs_oe   = 1'b0;
    if (dl_v[wl + 3'd1]) begin
      dq_pair  = dl_d[wl + 3'd1][2*DW-1:0];
      dq_oe    = 1'b1;
      dqs_oe   = 1'b1;
      dqs_half = 2'b01;
    end else if (dl_v[wl + 3'd2] && dl_l[wl + 3'd2]) begin
      dq_pair  = dl_d[wl + 3'd2][4*DW-1:2*DW];
      dq_oe    = 1'b1;
      dqs_oe   = 1'b1;
      dqs_half = 2'b01;
    end else if (dl_v[wl]) begin
      dqs_oe   = 1'b1;
    end
  end

  logic [CW-1:0] age [4];
  for (genvar b = 0; b < 4; b++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n)                                      age[b] <= CW'(T_RC);
      else if (cmd == CMD_OPEN && bank_out == 2'(b))   age[b] <= CW'(1);
      else if (age[b] < CW'(T_RC))                     age[b] <= age[b] + 1'b1;
    end
  end

  // R2
  open_then_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_OPEN |=> cmd == CMD_LAT);
  // R2
  take_issues_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cmd == CMD_OPEN && bank_out == $past(req_bank) && addr_out == $past(req_upper)));
  // R3
  bank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_OPEN |=> cmd != CMD_OPEN);
  // R4
  same_bank_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_OPEN |-> age[bank_out] >= CW'(T_RC));
  // R8
  strobe_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dqs_oe && dqs_half == 2'b01));
  // R8
  preamble_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(dqs_oe));
endmodule

// File: tb/nw_write_sched_test.sv
`timescale 1ns/1ps
module nw_write_sched_test;
  localparam int DW = 16;
  localparam int AW = 15;
  localparam int LG = 4096;

  logic clk = 0, rst_n = 0, cas_lat4 = 0;
  logic req_valid = 0, req_long = 0;
  logic req_ready;
  logic [1:0] req_bank = 0;
  logic [AW-1:0] req_upper = 0, req_lower = 0;
  logic [4*DW-1:0] req_data = 0;
  logic [1:0] cmd, bank_out, dqs_half;
  logic [AW-1:0] addr_out;
  logic [2*DW-1:0] dq_pair;
  logic dq_oe, dqs_oe;

  int checks = 0, errors = 0, cyc = 0;
  int lg_cmd [LG], lg_bank [LG], lg_addr [LG], lg_dqoe [LG], lg_dqsoe [LG], lg_dqs [LG];
  logic [2*DW-1:0] lg_dq [LG];

  nw_write_sched #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cas_lat4(cas_lat4),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_upper(req_upper), .req_lower(req_lower), .req_long(req_long), .req_data(req_data),
    .cmd(cmd), .bank_out(bank_out), .addr_out(addr_out),
    .dq_pair(dq_pair), .dq_oe(dq_oe), .dqs_half(dqs_half), .dqs_oe(dqs_oe));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (cyc < LG) begin
    lg_cmd[cyc] = int'(cmd); lg_bank[cyc] = int'(bank_out); lg_addr[cyc] = int'(addr_out);
    lg_dqoe[cyc] = int'(dq_oe); lg_dqsoe[cyc] = int'(dqs_oe); lg_dqs[cyc] = int'(dqs_half);
    lg_dq[cyc] = dq_pair;
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] b, input logic [AW-1:0] up, input logic [AW-1:0] lo,
                      input bit lng, input logic [4*DW-1:0] d, output int n);
    @(negedge clk);
    req_valid = 1; req_bank = b; req_upper = up; req_lower = lo; req_long = lng; req_data = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    n = cyc;
    req_valid = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(cmd == 2'b00, "R1 cmd in reset", cmd, 0);
    chk(!dq_oe && !dqs_oe, "R1 bus idle in reset", {dq_oe, dqs_oe}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
  endtask

  task automatic t_single(input bit cl4, input bit lng, input logic [1:0] b);
    int n, wl;
    logic [4*DW-1:0] d;
    d = {16'hC3C3 ^ 16'(b), 16'h2222, 16'h1111 + 16'(b), 16'hA5A5 ^ 16'(lng)};
    cas_lat4 = cl4;
    repeat (3) @(negedge clk);
    send(b, 15'h1234 + 15'(b), 15'h0567, lng, d, n);
    repeat (10) @(negedge clk);
    wl = cl4 ? 3 : 2;
    chk(lg_cmd[n] == 1, "R2 open command", lg_cmd[n], 1);
    chk(lg_bank[n] == int'(b), "R2 open bank", lg_bank[n], b);
    chk(lg_addr[n] == 'h1234 + int'(b), "R2 upper address", lg_addr[n], 'h1234 + b);
    chk(lg_cmd[n+1] == 2, "R2 latch command", lg_cmd[n+1], 2);
    chk(lg_addr[n+1] == 'h0567, "R2 lower address", lg_addr[n+1], 'h0567);
    chk(lg_cmd[n+2] == 0 && lg_cmd[n-1] == 0, "R5 deselect around pair", lg_cmd[n+2], 0);
    chk(lg_dqoe[n+wl] == 0, "R6 no data before latency", lg_dqoe[n+wl], 0);
    chk(lg_dqsoe[n+wl] == 1 && lg_dqs[n+wl] == 0, "R8 preamble", lg_dqs[n+wl], 0);
    chk(lg_dqoe[n+wl+1] == 1, "R6 data at latency", lg_dqoe[n+wl+1], 1);
    chk(lg_dq[n+wl+1] == d[2*DW-1:0], "R7 first pair", lg_dq[n+wl+1], d[2*DW-1:0]);
    chk(lg_dqs[n+wl+1] == 1 && lg_dqsoe[n+wl+1] == 1, "R8 strobe on data", lg_dqs[n+wl+1], 1);
    if (lng) begin
      chk(lg_dqoe[n+wl+2] == 1 && lg_dq[n+wl+2] == d[4*DW-1:2*DW], "R7 second pair",
          lg_dq[n+wl+2], d[4*DW-1:2*DW]);
      chk(lg_dqoe[n+wl+3] == 0, "R7 long burst end", lg_dqoe[n+wl+3], 0);
    end else
      chk(lg_dqoe[n+wl+2] == 0, "R7 short burst end", lg_dqoe[n+wl+2], 0);
  endtask

  task automatic t_b2b();
    int n1, n2;
    logic [4*DW-1:0] d1 = 64'h1003_1002_1001_1000, d2 = 64'h2003_2002_2001_2000;
    cas_lat4 = 0;
    repeat (3) @(negedge clk);
    send(2'd0, 15'h10, 15'h11, 1, d1, n1);
    send(2'd1, 15'h20, 15'h21, 1, d2, n2);
    repeat (10) @(negedge clk);
    chk(n2 - n1 == 2, "R3 different-bank spacing", n2 - n1, 2);
    chk(lg_cmd[n1+1] == 2 && lg_cmd[n2] == 1, "R3 latch then next open", lg_cmd[n2], 1);
    chk(lg_dq[n2+2] == d1[4*DW-1:2*DW] && lg_dqs[n2+2] == 1, "R8 no preamble when bursts abut",
        lg_dq[n2+2], d1[4*DW-1:2*DW]);
    chk(lg_dq[n2+3] == d2[2*DW-1:0] && lg_dqoe[n2+3] == 1, "R7 second burst first pair",
        lg_dq[n2+3], d2[2*DW-1:0]);
  endtask

  task automatic t_same();
    int n1, n2, bad;
    cas_lat4 = 1;
    repeat (3) @(negedge clk);
    send(2'd3, 15'h30, 15'h31, 0, 64'h3, n1);
    send(2'd3, 15'h40, 15'h41, 0, 64'h4, n2);
    repeat (8) @(negedge clk);
    chk(n2 - n1 == 5, "R4 same-bank spacing", n2 - n1, 5);
    bad = 0;
    for (int k = n1 + 2; k < n2; k++) if (lg_cmd[k] != 0) bad++;
    chk(bad == 0, "R5 deselect while waiting", bad, 0);
  endtask

  task automatic t_order();
    int n1, n2, n3, lowcnt;
    cas_lat4 = 0;
    repeat (3) @(negedge clk);
    send(2'd1, 15'h50, 15'h51, 0, 64'h5, n1);
    @(negedge clk);
    req_valid = 1; req_bank = 2'd1; req_upper = 15'h60; req_lower = 15'h61; req_long = 0;
    lowcnt = 0;
    for (int k = 0; k < 3; k++) begin
      if (!req_ready) lowcnt++;
      @(negedge clk);
    end
    chk(lowcnt == 3, "R9 ready low while head blocked", lowcnt, 3);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1; n2 = cyc; req_valid = 0;
    send(2'd2, 15'h70, 15'h71, 0, 64'h7, n3);
    repeat (8) @(negedge clk);
    lowcnt = 0;
    for (int k = n1 + 1; k < n2; k++) if (lg_cmd[k] == 1) lowcnt++;
    chk(lowcnt == 0, "R9 no open while head blocked", lowcnt, 0);
    chk(n2 - n1 == 5 && lg_addr[n2] == 'h60, "R9 blocked head issued first", n2 - n1, 5);
    chk(lg_bank[n3] == 2 && n3 - n2 == 2, "R9 later request after head", lg_bank[n3], 2);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_single(0, 0, 2'd2);
    t_single(1, 1, 2'd1);
    t_single(0, 1, 2'd0);
    t_single(1, 0, 2'd3);
    t_b2b();
    t_same();
    t_order();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule